// File: doc/BRIEF.md
# NVMe Page-List Pointer Builder

This block turns a host buffer description into the pair of 64-bit pointer values that fill dwords 6 through 9 of an NVMe command when physical region pages describe the data. A caller supplies a start address, a byte length and an address for a list page. When the transfer spans more than one page, the caller also feeds the physical addresses of the second and later pages on a valid/ready stream. The first page is always the start address itself, and that address may point partway into its 4 KiB page.

The block counts the pages that the transfer touches. From that count it picks one of three encodings for the second pointer. For one page it is zero. For two pages it is the second page's address. For three or more pages it is the list page address. In the list case, each incoming page address is emitted as one 8-byte entry, together with the byte address inside the list page where a downstream writer must store it. The block rejects requests it cannot encode: a zero length, more entries than one list page holds, a list page that is not page-aligned, or a misaligned page on the stream.

Top module: `prp_pointer_builder`

## Requirements
- R1: After reset, `done`, `err`, `ent_valid` and `pg_ready` are low and `prp1` and `prp2` are zero.
- R2: The page count is ceil((start_addr[11:0] + byte_len) / 4096). When the count is one, `done` pulses one cycle after `start`, with `prp1` equal to the full start address and `prp2` zero. No page is requested.
- R3: When the count is two, `pg_ready` rises one cycle after `start`. One page address is accepted. `done` pulses one cycle after that acceptance, with `prp2` equal to that address and no list entry emitted.
- R4: When the count is three or more, each accepted page address k (k = 0 for the second page of the transfer) gives, one cycle later, `ent_valid` high with `ent_data` equal to the address and `ent_addr` equal to `list_base + 8*k`.
- R5: In the list case, `done` pulses in the same cycle as the last list entry, with `prp1` equal to the start address and `prp2` equal to `list_base`.
- R6: A streamed page address with any of bits [11:0] set gives an `err` pulse one cycle after acceptance. That address produces no list entry, `done` does not pulse, and `pg_ready` drops in the same cycle.
- R7: A request with zero length, or with more than 513 pages (more than 512 list entries), gives an `err` pulse one cycle after `start`, with no `done` and no page request. Exactly 513 pages is accepted.
- R8: A request that needs a list, with `list_base[11:0]` non-zero, is rejected with `err` one cycle after `start`. A two-page request ignores `list_base`.
- R9: `start` is ignored while `pg_ready` is high. The request in progress completes with its own pointers.
- R10: `done` and `err` are single-cycle pulses and are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request strobe, sampled while idle |
| start_addr | input | 64 | Address of the first data byte |
| byte_len | input | 32 | Transfer length in bytes |
| list_base | input | 64 | Page address for the pointer list |
| pg_valid | input | 1 | Page address stream valid |
| pg_addr | input | 64 | Physical address of the next page (second page onward) |
| pg_ready | output | 1 | Block is accepting page addresses |
| done | output | 1 | Pointers are valid (one-cycle pulse) |
| err | output | 1 | Request rejected (one-cycle pulse) |
| prp1 | output | 64 | First pointer value |
| prp2 | output | 64 | Second pointer value |
| ent_valid | output | 1 | List entry valid |
| ent_addr | output | 64 | Byte address where the entry is stored |
| ent_data | output | 64 | Entry value (page address) |

## Verification
When the final page of a list-mode transfer is accepted, the last list entry and the completion pulse appear in the same cycle. The pointer registers switch to their final values on that same edge. The bench streams the pages of a four-page transfer back to back, and of a 513-page transfer, then samples after the edge that takes the last page. It expects `ent_valid` and `done` both high, the entry address at the last slot of the list, and `prp2` equal to the list page address. A misaligned page in the middle of a stream is checked on the same edge: the error must fire with neither an entry nor completion.

// File: rtl/prp_pointer_builder.sv
module prp_pointer_builder #(
  parameter int AW      = 64,
  parameter int LW      = 32,
  parameter int PB      = 12,
  parameter int MAX_ENT = 512
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [AW-1:0] start_addr,
  input  logic [LW-1:0] byte_len,
  input  logic [AW-1:0] list_base,
  input  logic          pg_valid,
  input  logic [AW-1:0] pg_addr,
  output logic          pg_ready,
  output logic          done,
  output logic          err,
  output logic [AW-1:0] prp1,
  output logic [AW-1:0] prp2,
  output logic          ent_valid,
  output logic [AW-1:0] ent_addr,
  output logic [AW-1:0] ent_data
);
  localparam int CW = $clog2(MAX_ENT + 2);
  localparam int NW = LW + 2;
  localparam logic [NW-1:0] PG_MASK = NW'((1 << PB) - 1);

  logic          busy, lst;
  logic [CW-1:0] left, idx;
  logic [AW-1:0] base;

  logic [NW-1:0] total, npg;
  logic          need_list, reject;

  assign total     = NW'(start_addr[PB-1:0]) + NW'(byte_len);
  assign npg       = (total + PG_MASK) >> PB;
  assign need_list = npg > NW'(2);
  assign reject    = (byte_len == '0) || (npg > NW'(MAX_ENT + 1)) ||
                     (need_list && list_base[PB-1:0] != '0);
  assign pg_ready  = busy;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0; lst <= 1'b0; left <= '0; idx <= '0; base <= '0;
      done <= 1'b0; err <= 1'b0; prp1 <= '0; prp2 <= '0;
      ent_valid <= 1'b0; ent_addr <= '0; ent_data <= '0;
    end else begin
      done <= 1'b0;
      err <= 1'b0;
      ent_valid <= 1'b0;
      if (!busy) begin
        if (start) begin
          if (reject) begin
            err <= 1'b1;
          end else if (npg == NW'(1)) begin
            done <= 1'b1;
            prp1 <= start_addr;
            prp2 <= '0;
          end else begin
            busy <= 1'b1;
            lst  <= need_list;
            left <= npg[CW-1:0] - CW'(1);
            idx  <= '0;
            prp1 <= start_addr;
            base <= list_base;
          end
        end
      end else if (pg_valid) begin
        if (pg_addr[PB-1:0] != '0) begin
          err  <= 1'b1;
          busy <= 1'b0;
        end else if (!lst) begin
          prp2 <= pg_addr;
          done <= 1'b1;
          busy <= 1'b0;
        end else begin
          ent_valid <= 1'b1;
          ent_addr  <= base + AW'({idx, 3'b000});
          ent_data  <= pg_addr;
          idx       <= idx + CW'(1);
          left      <= left - CW'(1);
          if (left == CW'(1)) begin
            done <= 1'b1;
            prp2 <= base;
            busy <= 1'b0;
          end
        end
      end
    end
  end

  a_r10_done_err_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && err));
  a_r10_done_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r6_entries_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    ent_valid |-> ent_data[PB-1:0] == '0);
  a_r3_prp2_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> prp2[PB-1:0] == '0);
  a_r4_entry_from_accept: assert property (@(posedge clk) disable iff (!rst_n)
    ent_valid |-> $past(pg_valid && pg_ready));
  a_r9_busy_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (pg_ready && !pg_valid) |=> pg_ready);
endmodule

// File: tb/prp_pointer_builder_tb.sv
module prp_pointer_builder_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [63:0] start_addr = '0;
  logic [31:0] byte_len = '0;
  logic [63:0] list_base = '0;
  logic        pg_valid = 1'b0;
  logic [63:0] pg_addr = '0;
  logic        pg_ready, done, err, ent_valid;
  logic [63:0] prp1, prp2, ent_addr, ent_data;

  int checks = 0;
  int fails = 0;
  bit ended = 1'b0;

  always #5 clk = ~clk;

  prp_pointer_builder u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .start_addr(start_addr),
    .byte_len(byte_len), .list_base(list_base), .pg_valid(pg_valid),
    .pg_addr(pg_addr), .pg_ready(pg_ready), .done(done), .err(err),
    .prp1(prp1), .prp2(prp2), .ent_valid(ent_valid), .ent_addr(ent_addr),
    .ent_data(ent_data)
  );

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic kick(input logic [63:0] sa, input logic [31:0] len, input logic [63:0] lb);
    start = 1'b1; start_addr = sa; byte_len = len; list_base = lb;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic push(input logic [63:0] a);
    pg_valid = 1'b1; pg_addr = a;
    @(negedge clk);
    pg_valid = 1'b0;
  endtask

  task automatic t_reset;
    chk(!done && !err && !ent_valid && !pg_ready, "R1 flags", {60'd0, done, err, ent_valid, pg_ready}, 64'd0);
    chk(prp1 == 64'd0 && prp2 == 64'd0, "R1 pointers", prp1 | prp2, 64'd0);
  endtask

  task automatic t_single;
    kick(64'h0000_0001_0000_0123, 32'h100, 64'h0);
    chk(done && !pg_ready, "R2 single page done", {62'd0, done, pg_ready}, 64'd2);
    chk(prp1 == 64'h0000_0001_0000_0123, "R2 prp1 keeps offset", prp1, 64'h0000_0001_0000_0123);
    chk(prp2 == 64'd0, "R2 prp2 zero", prp2, 64'd0);
    @(negedge clk);
    chk(!done, "R10 done one cycle", {63'd0, done}, 64'd0);
    kick(64'h0000_0000_2000_0F00, 32'h100, 64'h0);
    chk(done && prp2 == 64'd0, "R2 exact page end is one page", prp2, 64'd0);
    @(negedge clk);
  endtask

  task automatic t_two;
    kick(64'h0000_0000_2000_0800, 32'h1000, 64'h0000_0000_9000_0008);
    chk(pg_ready && !done && !err, "R3 two pages wait (R8 base ignored)", {61'd0, pg_ready, done, err}, 64'd4);
    push(64'h0000_0000_3000_5000);
    chk(done && !ent_valid, "R3 done without entry", {62'd0, done, ent_valid}, 64'd2);
    chk(prp2 == 64'h0000_0000_3000_5000, "R3 prp2 second page", prp2, 64'h0000_0000_3000_5000);
    chk(!pg_ready, "R3 stream closed", {63'd0, pg_ready}, 64'd0);
    @(negedge clk);
  endtask

  task automatic t_list;
    logic [63:0] b = 64'h0000_0000_9000_0000;
    kick(64'h0000_0000_4000_0010, 32'h3000, b);
    for (int k = 0; k < 3; k++) begin
      push(64'h0000_0000_5000_0000 + 64'(k) * 64'h2000);
      chk(ent_valid && ent_data == 64'h0000_0000_5000_0000 + 64'(k) * 64'h2000, "R4 entry data", ent_data, 64'h0000_0000_5000_0000 + 64'(k) * 64'h2000);
      chk(ent_addr == b + 64'(8 * k), "R4 entry address", ent_addr, b + 64'(8 * k));
      chk(done == (k == 2), "R5 done with last entry", {63'd0, done}, {63'd0, k == 2});
    end
    chk(prp1 == 64'h0000_0000_4000_0010 && prp2 == b, "R5 pointers in list mode", prp2, b);
    @(negedge clk);
  endtask

  task automatic t_misaligned;
    kick(64'h0000_0000_4000_0000, 32'h4000, 64'h0000_0000_9100_0000);
    push(64'h0000_0000_6000_0000);
    chk(ent_valid && !err, "R6 aligned page first", {62'd0, ent_valid, err}, 64'd2);
    push(64'h0000_0000_6000_1040);
    chk(err && !ent_valid && !done, "R6 misaligned rejected", {61'd0, err, ent_valid, done}, 64'd4);
    chk(!pg_ready, "R6 stream stops", {63'd0, pg_ready}, 64'd0);
    @(negedge clk);
    chk(!err && !done, "R10 err one cycle", {62'd0, err, done}, 64'd0);
  endtask

  task automatic t_limits;
    logic [63:0] b = 64'h0000_0000_A000_0000;
    kick(64'h0, 32'd0, b);
    chk(err && !pg_ready && !done, "R7 zero length", {61'd0, err, pg_ready, done}, 64'd4);
    @(negedge clk);
    kick(64'h0, 32'd514 * 32'h1000, b);
    chk(err && !pg_ready, "R7 514 pages rejected", {62'd0, err, pg_ready}, 64'd2);
    @(negedge clk);
    kick(64'h0000_0000_0000_0001, 32'd513 * 32'h1000, b);
    chk(err, "R7 offset pushes to 514 pages", {63'd0, err}, 64'd1);
    @(negedge clk);
    kick(64'h0000_0000_7000_0000, 32'd513 * 32'h1000, b);
    chk(pg_ready && !err, "R7 513 pages accepted", {62'd0, pg_ready, err}, 64'd2);
    for (int k = 0; k < 512; k++) begin
      push(64'h0000_0001_0000_0000 + 64'(k) * 64'h1000);
      if (k == 511) begin
        chk(ent_valid && done, "R5 last entry and done together", {62'd0, ent_valid, done}, 64'd3);
        chk(ent_addr == b + 64'd4088, "R7 last slot address", ent_addr, b + 64'd4088);
        chk(prp2 == b, "R7 prp2 list base", prp2, b);
      end else if (done) begin
        chk(1'b0, "R5 early done", 64'd1, 64'd0);
      end
    end
    @(negedge clk);
  endtask

  task automatic t_badbase;
    kick(64'h0000_0000_4000_0000, 32'h3000, 64'h0000_0000_9000_0008);
    chk(err && !pg_ready, "R8 misaligned list base", {62'd0, err, pg_ready}, 64'd2);
    @(negedge clk);
  endtask

  task automatic t_busy;
    logic [63:0] b = 64'h0000_0000_B000_0000;
    kick(64'h0000_0000_4400_0000, 32'h4000, b);
    push(64'h0000_0000_6100_0000);
    kick(64'h0000_0000_0000_0200, 32'h10, 64'h0);
    chk(!done && !err && pg_ready, "R9 start ignored while busy", {61'd0, done, err, pg_ready}, 64'd1);
    push(64'h0000_0000_6100_1000);
    chk(ent_addr == b + 64'd8, "R9 entry index kept", ent_addr, b + 64'd8);
    push(64'h0000_0000_6100_2000);
    chk(done && prp1 == 64'h0000_0000_4400_0000, "R9 original prp1", prp1, 64'h0000_0000_4400_0000);
    @(negedge clk);
  endtask

  task automatic finish_run;
    if (!ended) begin
      ended = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset;
    rst_n = 1'b1;
    @(negedge clk);
    t_single;
    t_two;
    t_list;
    t_misaligned;
    t_limits;
    t_badbase;
    t_busy;
    finish_run;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    finish_run;
  end
endmodule